// File: doc/BRIEF.md
# Software Write-Protect Command Detector

This block sits in front of the sector loader of one byte-wide flash segment. It watches the write cycles that the host sends on the card bus. It keeps a software protection flag for that segment. It also decides, cycle by cycle, whether a host write is passed on to the loader as array data or is held back.

Fixed command prefixes control the flag. Each prefix is a short run of writes, and each write carries a set data value at one of two key device addresses: key address A (5555h) and key address B (2AAAh).

- The three-write arming prefix is AAh@A, 55h@B, A0h@A. It turns protection on and opens a load window for the data that follows.
- The six-write release sequence is AAh@A, 55h@B, 80h@A, AAh@A, 55h@B, 20h@A. It turns protection off.

The card has sixteen segments, so one instance is placed per segment. Each instance is told which device pair and which side of the pair it serves. The even device answers even host byte addresses and the odd device answers odd ones.

The state machine has seven named states:

| State | Meaning |
|---|---|
| IDLE | No command in progress |
| U1 | AAh@A seen |
| U2 | 55h@B seen |
| D3 | 80h@A seen after U2 |
| D4 | second AAh@A seen |
| D5 | second 55h@B seen |
| LOAD | load window open |

Only a write to this segment (a selected write) moves the machine. Its transitions are:

| From | Write | To | Effect |
|---|---|---|---|
| IDLE | AAh@A | U1 | |
| U1 | 55h@B | U2 | |
| U2 | A0h@A | LOAD | protection set |
| U2 | 80h@A | D3 | |
| D3 | AAh@A | D4 | |
| D4 | 55h@B | D5 | |
| D5 | 20h@A | IDLE | protection cleared |
| LOAD | `load_end` high | IDLE | window closed |

If a selected write in U1 to D5 does not match the expected step, the machine takes the restart path. The write is then handled exactly as if the machine were in IDLE.

Top module: `swp_guard`

## Requirements
- R1: After reset, `prot_o` is 0, `window_o` is 0 and `load_wr_o` is 0 while no write is offered.
- R2: A host write belongs to this segment only when `host_addr[0]` equals ODD_SIDE and the top PAIR_W address bits equal PAIR_ID. The device address is `host_addr[DEV_AW:1]`, and command decoding compares only its low 15 bits against 5555h and 2AAAh.
- R3: While unprotected and with no command in progress, a selected write other than AAh to key address A raises `load_wr_o` in the same cycle.
- R4: The writes AAh@5555h, 55h@2AAAh, A0h@5555h in a row set `prot_o` and `window_o` at the clock edge of the third write. None of the three writes raises `load_wr_o`.
- R5: While `window_o` is 1, every selected write raises `load_wr_o`. A `load_end` pulse closes the window at its clock edge, and `prot_o` stays 1.
- R6: While `prot_o` is 1 and the window is closed, a selected write that is not a matching command step never raises `load_wr_o`.
- R7: The six-write release sequence clears `prot_o` at the clock edge of its sixth write. None of the six writes raises `load_wr_o`, and plain writes pass again afterwards.
- R8: A selected write that does not match the next expected step throws away the partial sequence. It is judged as a write in IDLE: it passes only if unprotected, and if it is AAh@5555h it starts a new sequence.
- R9: Writes that belong to another segment change neither this instance's state nor its outputs.
- R10: `load_end` outside the load window has no effect.
- R11: The arming prefix given while already protected opens a fresh load window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_addr | input | PAIR_W+DEV_AW+1 | Host byte address: {pair, device address, side} |
| host_data | input | 8 | Write data byte |
| load_end | input | 1 | End of the loader's load period |
| load_wr_o | output | 1 | Current write is passed to the sector loader |
| prot_o | output | 1 | Software protection is on |
| window_o | output | 1 | Post-arming load window is open |

## Verification
The bench drives the release sequence and breaks it after every prefix length from zero to five. A detector that kept partial progress after a bad write would then drop protection on a later, incomplete sequence. A detector that forgot the current protection level would let the breaking write through.

It sweeps all sixteen pair/side combinations with a key address whose upper device bits are set. A wrong select or over-wide key compare would arm the wrong segment or none at all.

It also checks the following corners:
- Every data value written while protected and outside the window must be blocked.
- A restart from the middle of a sequence must still arm.
- A stray `load_end`, or a write to the sibling segment, must change nothing.

// File: rtl/swp_pkg.sv
package swp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_U1,
        ST_U2,
        ST_D3,
        ST_D4,
        ST_D5,
        ST_LOAD
    } swp_state_e;

    typedef enum logic [2:0] {
        TK_OTHER,
        TK_AA_KA,
        TK_55_KB,
        TK_A0_KA,
        TK_80_KA,
        TK_20_KA
    } swp_tok_e;

    localparam logic [15:0] KEY_A = 16'h5555;
    localparam logic [15:0] KEY_B = 16'h2AAA;

endpackage

// File: rtl/swp_seg_sel.sv
module swp_seg_sel #(
    parameter int PAIR_W   = 3,
    parameter int DEV_AW   = 19,
    parameter int PAIR_ID  = 0,
    parameter int ODD_SIDE = 0
) (
    input  logic                     host_wr,
    input  logic [PAIR_W+DEV_AW:0]   host_addr,
    output logic                     seg_wr,
    output logic [DEV_AW-1:0]        dev_addr
);
    localparam int HOST_AW = PAIR_W + DEV_AW + 1;
    localparam logic [PAIR_W-1:0] MY_PAIR = PAIR_W'(PAIR_ID);
    localparam logic MY_SIDE = (ODD_SIDE != 0);

    logic pair_hit;
    logic side_hit;

    always_comb begin
        pair_hit = (host_addr[HOST_AW-1 -: PAIR_W] == MY_PAIR);
        side_hit = (host_addr[0] == MY_SIDE);
        seg_wr   = host_wr && pair_hit && side_hit;
        dev_addr = host_addr[DEV_AW:1];
    end
endmodule

// File: rtl/swp_cmd_match.sv
module swp_cmd_match
    import swp_pkg::*;
#(
    parameter int DEV_AW = 19,
    parameter int KEY_W  = 15
) (
    input  logic [DEV_AW-1:0] dev_addr,
    input  logic [7:0]        data,
    output swp_tok_e          tok
);
    localparam logic [KEY_W-1:0] KA = KEY_A[KEY_W-1:0];
    localparam logic [KEY_W-1:0] KB = KEY_B[KEY_W-1:0];

    logic at_a;
    logic at_b;

    always_comb begin
        at_a = (dev_addr[KEY_W-1:0] == KA);
        at_b = (dev_addr[KEY_W-1:0] == KB);
        tok  = TK_OTHER;
        if (at_a) begin
            unique case (data)
                8'hAA:   tok = TK_AA_KA;
                8'hA0:   tok = TK_A0_KA;
                8'h80:   tok = TK_80_KA;
                8'h20:   tok = TK_20_KA;
                default: tok = TK_OTHER;
            endcase
        end else if (at_b && data == 8'h55) begin
            tok = TK_55_KB;
        end
    end
endmodule

// File: rtl/swp_seq_fsm.sv
module swp_seq_fsm
    import swp_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     seg_wr,
    input  swp_tok_e tok,
    input  logic     load_end,
    output logic     load_wr,
    output logic     prot,
    output logic     window
);
    swp_state_e state_q, state_d;
    logic       prot_q, prot_d;
    logic       pass;
    swp_state_e rs_state;
    logic       rs_pass;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            prot_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            prot_q  <= prot_d;
        end
    end

    // next-state logic
    always_comb begin
        rs_state = (tok == TK_AA_KA) ? ST_U1 : ST_IDLE;
        rs_pass  = (tok != TK_AA_KA) && !prot_q;
        state_d  = state_q;
        prot_d   = prot_q;
        pass     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (seg_wr) begin
                    state_d = rs_state;
                    pass    = rs_pass;
                end
            end
            ST_U1: begin
                if (seg_wr) begin
                    if (tok == TK_55_KB) state_d = ST_U2;
                    else begin
                        state_d = rs_state;
                        pass    = rs_pass;
                    end
                end
            end
            ST_U2: begin
                if (seg_wr) begin
                    if (tok == TK_A0_KA) begin
                        state_d = ST_LOAD;
                        prot_d  = 1'b1;
                    end else if (tok == TK_80_KA) begin
                        state_d = ST_D3;
                    end else begin
                        state_d = rs_state;
                        pass    = rs_pass;
                    end
                end
            end
            ST_D3: begin
                if (seg_wr) begin
                    if (tok == TK_AA_KA) state_d = ST_D4;
                    else begin
                        state_d = rs_state;
                        pass    = rs_pass;
                    end
                end
            end
            ST_D4: begin
                if (seg_wr) begin
                    if (tok == TK_55_KB) state_d = ST_D5;
                    else begin
                        state_d = rs_state;
                        pass    = rs_pass;
                    end
                end
            end
            ST_D5: begin
                if (seg_wr) begin
                    if (tok == TK_20_KA) begin
                        state_d = ST_IDLE;
                        prot_d  = 1'b0;
                    end else begin
                        state_d = rs_state;
                        pass    = rs_pass;
                    end
                end
            end
            ST_LOAD: begin
                pass = seg_wr;
                if (load_end) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        load_wr = seg_wr && pass;
        prot    = prot_q;
        window  = (state_q == ST_LOAD);
    end

    assert_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_q && state_q != ST_LOAD) |-> !load_wr);

    assert_arm_path_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prot_q) |-> ($past(state_q) == ST_U2 && state_q == ST_LOAD));

    assert_release_path_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prot_q) |-> ($past(state_q) == ST_D5));

    assert_window_prot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD) |-> prot_q);

    assert_quiet_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!seg_wr && state_q != ST_LOAD) |=> ($stable(state_q) && $stable(prot_q)));

    assert_cmd_no_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q inside {ST_U1, ST_D3, ST_D4, ST_D5} && seg_wr && tok != TK_OTHER &&
         !(prot_q == 1'b0 && tok != TK_AA_KA && state_q == ST_U1 && tok != TK_55_KB))
        |-> (!load_wr || !prot_q));
endmodule

// File: rtl/swp_guard.sv
module swp_guard
    import swp_pkg::*;
#(
    parameter int PAIR_W   = 3,
    parameter int DEV_AW   = 19,
    parameter int KEY_W    = 15,
    parameter int PAIR_ID  = 0,
    parameter int ODD_SIDE = 0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   host_wr,
    input  logic [PAIR_W+DEV_AW:0] host_addr,
    input  logic [7:0]             host_data,
    input  logic                   load_end,
    output logic                   load_wr_o,
    output logic                   prot_o,
    output logic                   window_o
);
    logic              seg_wr;
    logic [DEV_AW-1:0] dev_addr;
    swp_tok_e          tok;

    swp_seg_sel #(
        .PAIR_W  (PAIR_W),
        .DEV_AW  (DEV_AW),
        .PAIR_ID (PAIR_ID),
        .ODD_SIDE(ODD_SIDE)
    ) u_sel (
        .host_wr  (host_wr),
        .host_addr(host_addr),
        .seg_wr   (seg_wr),
        .dev_addr (dev_addr)
    );

    swp_cmd_match #(
        .DEV_AW(DEV_AW),
        .KEY_W (KEY_W)
    ) u_match (
        .dev_addr(dev_addr),
        .data    (host_data),
        .tok     (tok)
    );

    swp_seq_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .seg_wr  (seg_wr),
        .tok     (tok),
        .load_end(load_end),
        .load_wr (load_wr_o),
        .prot    (prot_o),
        .window  (window_o)
    );
endmodule

// File: tb/swp_guard_tb.sv
`timescale 1ns/1ps
module swp_guard_tb;
    localparam int MY_PAIR = 5;
    localparam int MY_SIDE = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [22:0] host_addr = '0;
    logic [7:0]  host_data = '0;
    logic        load_end = 1'b0;
    logic        load_wr_o, prot_o, window_o;
    logic        p_load_wr, p_prot, p_window;

    int checks = 0;
    int fails  = 0;
    int last_pass;
    int last_ppass;

    always #10 clk = ~clk;

    swp_guard #(.PAIR_ID(MY_PAIR), .ODD_SIDE(MY_SIDE)) u_dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_data(host_data), .load_end(load_end),
        .load_wr_o(load_wr_o), .prot_o(prot_o), .window_o(window_o));

    swp_guard #(.PAIR_ID(MY_PAIR), .ODD_SIDE(0)) u_peer (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_data(host_data), .load_end(load_end),
        .load_wr_o(p_load_wr), .prot_o(p_prot), .window_o(p_window));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // one write cycle; called at a negedge, returns at the next negedge
    task automatic wr(input int pair, input int side, input logic [18:0] dev, input logic [7:0] d);
        host_addr = {3'(pair), dev, 1'(side)};
        host_data = d;
        host_wr   = 1'b1;
        #2;
        last_pass  = int'(load_wr_o);
        last_ppass = int'(p_load_wr);
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic wr_me(input logic [18:0] dev, input logic [7:0] d);
        wr(MY_PAIR, MY_SIDE, dev, d);
    endtask

    task automatic pulse_end();
        load_end = 1'b1;
        @(negedge clk);
        load_end = 1'b0;
    endtask

    task automatic arm_me(input string req);
        wr_me(19'h05555, 8'hAA); chk({req, " cmd1 blocked"}, last_pass, 0);
        wr_me(19'h02AAA, 8'h55); chk({req, " cmd2 blocked"}, last_pass, 0);
        wr_me(19'h05555, 8'hA0); chk({req, " cmd3 blocked"}, last_pass, 0);
    endtask

    task automatic release_steps(input int n);
        logic [18:0] a [6];
        logic [7:0]  d [6];
        a = '{19'h05555, 19'h02AAA, 19'h05555, 19'h05555, 19'h02AAA, 19'h05555};
        d = '{8'hAA, 8'h55, 8'h80, 8'hAA, 8'h55, 8'h20};
        for (int i = 0; i < n; i++) begin
            wr_me(a[i], d[i]);
            chk("R7 release step blocked", last_pass, 0);
        end
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 prot", int'(prot_o), 0);
        chk("R1 window", int'(window_o), 0);
        chk("R1 load_wr", int'(load_wr_o), 0);

        // R3 unprotected writes pass, every data value at a non-key address
        for (int v = 0; v < 256; v++) begin
            wr_me(19'h01234, 8'(v));
            chk("R3 plain write passes", last_pass, 1);
        end
        // R9 sibling never sees writes of this segment
        chk("R9 peer load_wr", last_ppass, 0);

        // R8 AA@A consumed, breaking write judged as idle (unprotected -> pass)
        wr_me(19'h05555, 8'hAA); chk("R3 AA at key A consumed", last_pass, 0);
        wr_me(19'h00000, 8'h00); chk("R8 breaking write passes unprotected", last_pass, 1);
        chk("R8 still unprotected", int'(prot_o), 0);

        // R2 sweep all pairs and sides; key compare uses low 15 device bits
        for (int p = 0; p < 8; p++) begin
            for (int s = 0; s < 2; s++) begin
                do_reset();
                wr(p, s, 19'h7D555, 8'hAA);
                wr(p, s, 19'h42AAA, 8'h55);
                wr(p, s, 19'h3D555, 8'hA0);
                chk("R2 dut armed only by own segment", int'(prot_o),
                    (p == MY_PAIR && s == MY_SIDE) ? 1 : 0);
                chk("R9 peer armed only by own segment", int'(p_prot),
                    (p == MY_PAIR && s == 0) ? 1 : 0);
            end
        end

        // R4 arming sequence
        do_reset();
        arm_me("R4");
        chk("R4 prot set", int'(prot_o), 1);
        chk("R4 window open", int'(window_o), 1);
        chk("R9 peer untouched", int'(p_prot), 0);

        // R5 window passes writes, load_end closes it
        for (int i = 0; i < 8; i++) begin
            wr_me(19'(i * 7), 8'(i * 37));
            chk("R5 window write passes", last_pass, 1);
        end
        wr_me(19'h05555, 8'hAA);
        chk("R5 key data passes in window", last_pass, 1);
        pulse_end();
        chk("R5 window closed", int'(window_o), 0);
        chk("R5 prot kept", int'(prot_o), 1);

        // R6 protected, window closed: all data blocked
        for (int v = 0; v < 256; v++) begin
            if (v != 8'hAA) begin
                wr_me(19'h00100, 8'(v));
                chk("R6 protected write blocked", last_pass, 0);
            end
        end
        chk("R6 prot held", int'(prot_o), 1);

        // R10 stray load_end ignored
        pulse_end();
        chk("R10 window stays closed", int'(window_o), 0);
        chk("R10 prot unchanged", int'(prot_o), 1);
        wr_me(19'h00100, 8'h42);
        chk("R10 still blocked", last_pass, 0);

        // R11 rearm while protected
        arm_me("R11");
        chk("R11 window reopened", int'(window_o), 1);
        wr_me(19'h00200, 8'h99);
        chk("R11 load passes", last_pass, 1);
        pulse_end();

        // R8 break release sequence at each prefix length
        for (int k = 0; k < 6; k++) begin
            release_steps(k);
            wr_me(19'h00100, 8'h11);
            chk("R8 breaking write blocked while protected", last_pass, 0);
            chk("R8 prot kept after break", int'(prot_o), 1);
            // a later partial remainder must not release
            wr_me(19'h05555, 8'h20);
            chk("R8 stale progress discarded", int'(prot_o), 1);
        end

        // R8 restart from mid-sequence with AA@A
        wr_me(19'h05555, 8'hAA);
        wr_me(19'h02AAA, 8'h55);
        arm_me("R8 restart");
        chk("R8 restart arms", int'(window_o), 1);
        pulse_end();

        // R7 release
        release_steps(6);
        chk("R7 prot cleared", int'(prot_o), 0);
        wr_me(19'h00300, 8'h5A);
        chk("R7 plain write passes again", last_pass, 1);
        pulse_end();
        wr_me(19'h00300, 8'h5B);
        chk("R10 load_end ignored unprotected", last_pass, 1);

        // R9 peer release independent
        chk("R9 peer still unprotected", int'(p_prot), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule